// File: doc/BRIEF.md
# Error Register Dump Sequencer

After a fault in one unit, this block collects that unit's diagnostic register contents without help from software. It acts as a master on a simple register bus and has one transaction in flight at a time. It first reads an error-list pointer register. If the pointer is valid, it walks a chain of 64-bit dump descriptors and performs the reads that each descriptor asks for. It then visits eight diagnostic rings in turn. For each ring it programs a selector register with a (ring, trace) code and drains the selected trap or trace buffer through a mailbox register.

Every word read out of the unit (not the pointer, descriptor, map or selector accesses) is delivered as one record on a valid/ready stream. A record carries the address that was read, an index tag and the 64-bit value. The unit is placed in the address space by the `unitBase` input, which is ORed into every address the block generates. A record counter stops at a configured maximum. Once it is reached, further records are suppressed and an overflow flag is raised, but the walk itself runs to the end.

Top module: `err_dump_seq`

## Requirements
- R1: When the pointer register (at `unitBase | PTR_OFFS`) reads 0 or all ones, no descriptor is fetched and the block goes straight to the ring phase.
- R2: Descriptors are fetched from `unitBase | pointer`, then from each following 8-byte address. The list ends at the first descriptor equal to 0 or all ones, which produces no records.
- R3: A descriptor holds the target address in bits 23:0, a length in bits 38:24 and a mode bit in bit 39. The target address is ORed with `unitBase`.
- R4: Mode bit 1 (repeat): the same address is read `length` times. Record k carries index k, counting from 0.
- R5: Mode bit 0 (sequential): `length` is a byte count. `length/8` words are read, rounded down, at addresses rising by 8, each with index 0. Lengths of 0 to 7 give no read.
- R6: For ring r = 0..7, the map register at `unitBase | (MAP_OFFS + 8*r)` is read. A ring whose map reads 0 or all ones is skipped.
- R7: The map holds the trap count in bits 31:24, the trace count in bits 23:16 and the entries per trace in bits 15:0. For each trace t from 0 to the trace count inclusive, the value `r*256 + t` is written to `unitBase | SEL_OFFS`, even when no mailbox read follows.
- R8: After each selector write, `unitBase | MBX_OFFS` is read the trap count of times when t = 0, and the entries-per-trace count of times otherwise. The index of read e is `(selector << 16) | e`.
- R9: A bus request holds its address and direction until `busAck`. No new request is made while a captured record waits on the stream.
- R10: A record offered with `recValid` keeps its address, index and data unchanged until `recReady` accepts it.
- R11: `recCount` counts accepted records and stops at `MAX_RECS`. Later records are not offered, `overflow` is set, and both are cleared by the next `start`.
- R12: `done` pulses for one cycle when the ring phase ends, after which `busy` is low. A `start` seen while `busy` is high has no effect.
- R13: After reset the block is idle: no request, no record, `recCount` = 0 and `overflow` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a dump (ignored while busy) |
| unitBase | input | ADDR_W | Unit base ORed into every address |
| busReq | output | 1 | Bus transaction request |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | ADDR_W | Transaction address |
| busWdata | output | 64 | Write data (selector value) |
| busAck | input | 1 | Transaction complete; read data valid |
| busRdata | input | 64 | Read data |
| recValid | output | 1 | Record offered |
| recReady | input | 1 | Record accepted |
| recAddr | output | ADDR_W | Address the record was read from |
| recIdx | output | 32 | Record index tag |
| recData | output | 64 | Value read |
| recCount | output | clog2(MAX_RECS+1) | Accepted record count |
| overflow | output | 1 | Records were suppressed at the limit |
| busy | output | 1 | Dump in progress |
| done | output | 1 | One-cycle end-of-dump pulse |

## Verification
The bus-hold and record-hold properties assume a slave that raises `busAck` only while `busReq` is high, for a single cycle, and a consumer whose `recReady` has no effect unless a record is offered. The bench's register model answers each request after a random 0 to 2 cycles of wait and drops its acknowledge on the next cycle. It changes `recReady` only at the inactive clock edge. Descriptor lists always end in a terminator, and their target regions are kept apart from the pointer, map, selector and mailbox registers, so that every read the bench expects has one unambiguous value.

// File: rtl/err_dump_pkg.sv
package err_dump_pkg;
  localparam int WORD_W = 64;
  localparam int IDX_W  = 32;
  localparam int LEN_W  = 15;
  localparam int CNT16  = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PTR, ST_DESC, ST_DUMP, ST_DEMIT,
    ST_MAP, ST_SEL, ST_MBX, ST_MEMIT, ST_DONE
  } seqStateT;

  typedef enum logic [2:0] {
    AS_PTR, AS_DESC, AS_DUMP, AS_MAP, AS_SEL, AS_MBX
  } addrSelT;

  typedef struct packed {
    logic    clrRun;
    logic    ldList;
    logic    ldDesc;
    logic    stepCnt;
    logic    ldMap;
    logic    nextRing;
    logic    nextTrace;
    logic    clrCnt;
    logic    capRec;
    logic    takeRec;
    logic    setOvf;
    addrSelT addrSel;
  } ctlT;

  typedef struct packed {
    logic rdBad;
    logic descEmpty;
    logic dumpLast;
    logic ringLast;
    logic traceLast;
    logic mbxEmpty;
    logic mbxLast;
    logic full;
  } stsT;
endpackage

// File: rtl/err_dump_ctrl.sv
module err_dump_ctrl
  import err_dump_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic busAck,
  input  logic recReady,
  input  stsT  sts,
  output ctlT  ctl,
  output logic busReq,
  output logic busWe,
  output logic recValid,
  output logic busy,
  output logic done
);
  seqStateT st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    logic adv, toTrace, toRing;
    ctl      = '0;
    ctl.addrSel = AS_PTR;
    busReq   = 1'b0;
    busWe    = 1'b0;
    recValid = 1'b0;
    done     = 1'b0;
    nxt      = st;
    adv      = 1'b0;
    toTrace  = 1'b0;
    toRing   = 1'b0;
    case (st)
      ST_IDLE: if (start) begin ctl.clrRun = 1'b1; nxt = ST_PTR; end
      ST_PTR: begin
        busReq = 1'b1; ctl.addrSel = AS_PTR;
        if (busAck) begin
          if (sts.rdBad) nxt = ST_MAP;
          else begin ctl.ldList = 1'b1; nxt = ST_DESC; end
        end
      end
      ST_DESC: begin
        busReq = 1'b1; ctl.addrSel = AS_DESC;
        if (busAck) begin
          if (sts.rdBad) nxt = ST_MAP;
          else begin
            ctl.ldDesc = 1'b1;
            nxt = sts.descEmpty ? ST_DESC : ST_DUMP;
          end
        end
      end
      ST_DUMP: begin
        busReq = 1'b1; ctl.addrSel = AS_DUMP;
        if (busAck) begin ctl.capRec = 1'b1; nxt = ST_DEMIT; end
      end
      ST_MAP: begin
        busReq = 1'b1; ctl.addrSel = AS_MAP;
        if (busAck) begin
          if (sts.rdBad) toRing = 1'b1;
          else begin ctl.ldMap = 1'b1; nxt = ST_SEL; end
        end
      end
      ST_SEL: begin
        busReq = 1'b1; busWe = 1'b1; ctl.addrSel = AS_SEL;
        if (busAck) begin
          ctl.clrCnt = 1'b1;
          if (sts.mbxEmpty) toTrace = 1'b1;
          else nxt = ST_MBX;
        end
      end
      ST_MBX: begin
        busReq = 1'b1; ctl.addrSel = AS_MBX;
        if (busAck) begin ctl.capRec = 1'b1; nxt = ST_MEMIT; end
      end
      ST_DEMIT, ST_MEMIT: begin
        ctl.addrSel = (st == ST_MEMIT) ? AS_MBX : AS_DUMP;
        if (sts.full) begin ctl.setOvf = 1'b1; adv = 1'b1; end
        else begin
          recValid = 1'b1;
          if (recReady) begin ctl.takeRec = 1'b1; adv = 1'b1; end
        end
        if (adv) begin
          ctl.stepCnt = 1'b1;
          if (st == ST_DEMIT) nxt = sts.dumpLast ? ST_DESC : ST_DUMP;
          else if (sts.mbxLast) toTrace = 1'b1;
          else nxt = ST_MBX;
        end
      end
      ST_DONE: begin done = 1'b1; nxt = ST_IDLE; end
      default: nxt = ST_IDLE;
    endcase
    if (toTrace) begin
      if (!sts.traceLast) begin ctl.nextTrace = 1'b1; nxt = ST_SEL; end
      else toRing = 1'b1;
    end
    if (toRing) begin
      if (sts.ringLast) nxt = ST_DONE;
      else begin ctl.nextRing = 1'b1; nxt = ST_MAP; end
    end
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/err_dump_path.sv
module err_dump_path
  import err_dump_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_RECS  = 64,
  parameter int NUM_RINGS = 8,
  parameter logic [ADDR_W-1:0] PTR_OFFS = 'h100,
  parameter logic [ADDR_W-1:0] MAP_OFFS = 'h200,
  parameter logic [ADDR_W-1:0] SEL_OFFS = 'h300,
  parameter logic [ADDR_W-1:0] MBX_OFFS = 'h308,
  localparam int CNT_W  = $clog2(MAX_RECS + 1),
  localparam int RING_W = $clog2(NUM_RINGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlT                ctl,
  input  logic [ADDR_W-1:0]  unitBase,
  input  logic [WORD_W-1:0]  busRdata,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [WORD_W-1:0]  busWdata,
  output logic [ADDR_W-1:0]  recAddr,
  output logic [IDX_W-1:0]   recIdx,
  output logic [WORD_W-1:0]  recData,
  output logic [CNT_W-1:0]   recCount,
  output logic               overflow,
  output stsT                sts
);
  logic [ADDR_W-1:0] listAddr, dumpAddr;
  logic [LEN_W-1:0]  dumpLen;
  logic              dumpRep;
  logic [CNT16-1:0]  idxCnt;
  logic [RING_W-1:0] ringNo;
  logic [7:0]        traceNo, trapTot, traceTot;
  logic [CNT16-1:0]  entryTot, mbxTot;
  logic [LEN_W-1:0]  descLen;
  logic [RING_W+7:0] selVal;

  assign descLen  = busRdata[39] ? busRdata[38:24] : {3'b000, busRdata[38:27]};
  assign selVal   = {ringNo, traceNo};
  assign mbxTot   = (traceNo == 8'd0) ? {8'd0, trapTot} : entryTot;
  assign busWdata = WORD_W'(selVal);

  always_comb begin
    case (ctl.addrSel)
      AS_PTR:  busAddr = unitBase | PTR_OFFS;
      AS_DESC: busAddr = listAddr;
      AS_DUMP: busAddr = dumpAddr;
      AS_MAP:  busAddr = unitBase | (MAP_OFFS + ADDR_W'({ringNo, 3'b000}));
      AS_SEL:  busAddr = unitBase | SEL_OFFS;
      default: busAddr = unitBase | MBX_OFFS;
    endcase
  end

  always_comb begin
    sts.rdBad     = (busRdata == '0) || (&busRdata);
    sts.descEmpty = (descLen == '0);
    sts.dumpLast  = ({1'b0, idxCnt} + 17'd1) == 17'(dumpLen);
    sts.ringLast  = (ringNo == RING_W'(NUM_RINGS - 1));
    sts.traceLast = (traceNo == traceTot);
    sts.mbxEmpty  = (mbxTot == '0);
    sts.mbxLast   = ({1'b0, idxCnt} + 17'd1) == {1'b0, mbxTot};
    sts.full      = (recCount == CNT_W'(MAX_RECS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      listAddr <= '0; dumpAddr <= '0; dumpLen <= '0; dumpRep <= 1'b0;
      idxCnt <= '0; ringNo <= '0; traceNo <= '0; trapTot <= '0;
      traceTot <= '0; entryTot <= '0; recAddr <= '0; recIdx <= '0;
      recData <= '0; recCount <= '0; overflow <= 1'b0;
    end else begin
      if (ctl.clrRun) begin
        ringNo <= '0; recCount <= '0; overflow <= 1'b0;
      end
      if (ctl.ldList) listAddr <= unitBase | busRdata[ADDR_W-1:0];
      if (ctl.ldDesc) begin
        listAddr <= listAddr + ADDR_W'(8);
        dumpAddr <= unitBase | ADDR_W'(busRdata[23:0]);
        dumpLen  <= descLen;
        dumpRep  <= busRdata[39];
        idxCnt   <= '0;
      end
      if (ctl.stepCnt) begin
        idxCnt <= idxCnt + 1'b1;
        if (!dumpRep) dumpAddr <= dumpAddr + ADDR_W'(8);
      end
      if (ctl.clrCnt) idxCnt <= '0;
      if (ctl.ldMap) begin
        trapTot  <= busRdata[31:24];
        traceTot <= busRdata[23:16];
        entryTot <= busRdata[15:0];
        traceNo  <= '0;
      end
      if (ctl.nextTrace) traceNo <= traceNo + 1'b1;
      if (ctl.nextRing)  ringNo <= ringNo + 1'b1;
      if (ctl.capRec) begin
        recAddr <= busAddr;
        recData <= busRdata;
        if (ctl.addrSel == AS_MBX) recIdx <= IDX_W'({selVal, idxCnt});
        else if (dumpRep)          recIdx <= IDX_W'(idxCnt);
        else                       recIdx <= '0;
      end
      if (ctl.takeRec) recCount <= recCount + 1'b1;
      if (ctl.setOvf)  overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/err_dump_seq.sv
module err_dump_seq
  import err_dump_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_RECS  = 64,
  parameter int NUM_RINGS = 8,
  parameter logic [ADDR_W-1:0] PTR_OFFS = 'h100,
  parameter logic [ADDR_W-1:0] MAP_OFFS = 'h200,
  parameter logic [ADDR_W-1:0] SEL_OFFS = 'h300,
  parameter logic [ADDR_W-1:0] MBX_OFFS = 'h308
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [ADDR_W-1:0]            unitBase,
  output logic                         busReq,
  output logic                         busWe,
  output logic [ADDR_W-1:0]            busAddr,
  output logic [63:0]                  busWdata,
  input  logic                         busAck,
  input  logic [63:0]                  busRdata,
  output logic                         recValid,
  input  logic                         recReady,
  output logic [ADDR_W-1:0]            recAddr,
  output logic [31:0]                  recIdx,
  output logic [63:0]                  recData,
  output logic [$clog2(MAX_RECS+1)-1:0] recCount,
  output logic                         overflow,
  output logic                         busy,
  output logic                         done
);
  ctlT ctl;
  stsT sts;

  err_dump_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .busAck(busAck),
    .recReady(recReady), .sts(sts), .ctl(ctl), .busReq(busReq),
    .busWe(busWe), .recValid(recValid), .busy(busy), .done(done)
  );

  err_dump_path #(
    .ADDR_W(ADDR_W), .MAX_RECS(MAX_RECS), .NUM_RINGS(NUM_RINGS),
    .PTR_OFFS(PTR_OFFS), .MAP_OFFS(MAP_OFFS),
    .SEL_OFFS(SEL_OFFS), .MBX_OFFS(MBX_OFFS)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .unitBase(unitBase),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata),
    .recAddr(recAddr), .recIdx(recIdx), .recData(recData),
    .recCount(recCount), .overflow(overflow), .sts(sts)
  );
endmodule

// File: rtl/err_dump_chk.sv
module err_dump_chk #(
  parameter int ADDR_W   = 32,
  parameter int MAX_RECS = 64,
  parameter int CNT_W    = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWe,
  input logic              busAck,
  input logic [ADDR_W-1:0] busAddr,
  input logic              recValid,
  input logic              recReady,
  input logic [ADDR_W-1:0] recAddr,
  input logic [31:0]       recIdx,
  input logic [63:0]       recData,
  input logic [CNT_W-1:0]  recCount,
  input logic              overflow,
  input logic              busy,
  input logic              done
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWe)); // R9
  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rstN)
    !(busReq && recValid)); // R9
  AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recReady |=> recValid && $stable(recAddr) && $stable(recIdx) && $stable(recData)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> recCount < CNT_W'(MAX_RECS)); // R11
  AST_OVF_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> recCount == CNT_W'(MAX_RECS)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq && !recValid); // R13
endmodule

bind err_dump_seq err_dump_chk #(
  .ADDR_W(ADDR_W), .MAX_RECS(MAX_RECS), .CNT_W($clog2(MAX_RECS+1))
) uChk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAck(busAck),
  .busAddr(busAddr), .recValid(recValid), .recReady(recReady),
  .recAddr(recAddr), .recIdx(recIdx), .recData(recData),
  .recCount(recCount), .overflow(overflow), .busy(busy), .done(done)
);

// File: tb/sim_err_dump_seq.sv
module sim_err_dump_seq;
  localparam logic [31:0] BASE = 32'h0200_0000;
  localparam logic [31:0] PTRO = 32'h100, MAPO = 32'h200, SELO = 32'h300;
  localparam logic [31:0] MBXO = 32'h308, LIST = 32'h800;
  localparam int MAXR = 64;

  logic clk = 0, rstN = 0, start = 0, busAck = 0, recReady = 0;
  logic [63:0] busRdata = '0;
  logic busReq, busWe, recValid, overflow, busy, done;
  logic [31:0] busAddr, recAddr, recIdx;
  logic [63:0] busWdata, recData;
  logic [6:0] recCount;

  err_dump_seq u0 (.*, .unitBase(BASE));

  always #10 clk = ~clk;

  logic [63:0] ptrVal, descArr[16], mapArr[8];
  logic [15:0] selReg = '0, mbxCnt = '0;
  logic [31:0] expA[$], expI[$];
  logic [63:0] expD[$];
  int vectors = 0, fails = 0, recvIdx = 0, doneCnt = 0, waitCnt = 0, cyc = 0;
  bit bpMode = 0, doneSeen = 0;

  function automatic logic [63:0] hashData(input logic [31:0] a);
    return {a ^ 32'hC3A5_0F0F, ~a + 32'h1357};
  endfunction

  function automatic logic [63:0] modelRead(input logic [31:0] a);
    if (a == (BASE | PTRO)) return ptrVal;
    if (a >= (BASE | MAPO) && a < (BASE | MAPO) + 64) return mapArr[(a - (BASE | MAPO)) >> 3];
    if (a >= (BASE | LIST) && a < (BASE | LIST) + 128) return descArr[(a - (BASE | LIST)) >> 3];
    return hashData(a);
  endfunction

  function automatic logic [63:0] mbxVal(input logic [15:0] sel, input logic [15:0] e);
    return {16'hA5A5, sel, 16'h0000, e};
  endfunction

  task automatic push(input logic [31:0] a, input logic [31:0] i, input logic [63:0] d);
    expA.push_back(a); expI.push_back(i); expD.push_back(d);
  endtask

  // independent model of the walk, from the requirements
  task automatic buildExpected();
    expA.delete(); expI.delete(); expD.delete();
    if (ptrVal != 64'd0 && ptrVal != '1) begin
      for (int k = 0; k < 32; k++) begin
        logic [63:0] e;
        logic [31:0] a;
        int n;
        e = modelRead((BASE | ptrVal[31:0]) + 32'(8 * k));
        if (e == 64'd0 || e == '1) break;
        a = BASE | {8'd0, e[23:0]};                 // R3
        n = int'(e[38:24]);
        if (e[39]) for (int i = 0; i < n; i++) push(a, 32'(i), hashData(a));  // R4
        else for (int i = 0; i < n / 8; i++) push(a + 32'(8 * i), 0, hashData(a + 32'(8 * i)));  // R5
      end
    end
    for (int r = 0; r < 8; r++) begin
      logic [63:0] m;
      m = mapArr[r];
      if (m == 64'd0 || m == '1) continue;          // R6
      for (int t = 0; t <= int'(m[23:16]); t++) begin
        int n;
        logic [15:0] sel;
        sel = 16'(r * 256 + t);                     // R7
        n = (t == 0) ? int'(m[31:24]) : int'(m[15:0]);
        for (int e = 0; e < n; e++) push(BASE | MBXO, {sel, 16'(e)}, mbxVal(sel, 16'(e)));  // R8
      end
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkRecord();
    string req;
    if (recvIdx >= expA.size()) begin
      chk(0, "R11", "extra record", longint'(recvIdx), longint'(expA.size()));
    end else begin
      req = (expA[recvIdx] == (BASE | MBXO)) ? "R8" : "R3";
      chk(recAddr == expA[recvIdx], req, "record addr", longint'(recAddr), longint'(expA[recvIdx]));
      chk(recIdx == expI[recvIdx], req, "record index", longint'(recIdx), longint'(expI[recvIdx]));
      chk(recData == expD[recvIdx], req, "record data", longint'(recData), longint'(expD[recvIdx]));
    end
    recvIdx++;
  endtask

  always @(negedge clk) begin
    cyc++;
    recReady = bpMode ? 1'($urandom % 2) : 1'b1;
    if (recValid && recReady) checkRecord();
    if (done) begin doneSeen = 1; doneCnt++; end
    if (busAck) busAck = 1'b0;
    else if (busReq) begin
      if (waitCnt == 0) begin
        if (busWe) begin
          if (busAddr == (BASE | SELO)) begin selReg = busWdata[15:0]; mbxCnt = 0; end
        end else if (busAddr == (BASE | MBXO)) begin
          busRdata = mbxVal(selReg, mbxCnt); mbxCnt++;
        end else busRdata = modelRead(busAddr);
        busAck = 1'b1;
        waitCnt = $urandom % 3;
      end else waitCnt--;
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic runTest(input bit bp, input bit dblStart);
    int expN;
    buildExpected();
    bpMode = bp; recvIdx = 0; doneSeen = 0; doneCnt = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (dblStart) begin
      repeat (15) @(negedge clk);
      chk(busy == 1'b1, "R12", "busy mid-run", longint'(busy), 1);
      start = 1; @(negedge clk); start = 0;
    end
    while (!doneSeen) @(negedge clk);
    repeat (4) @(negedge clk);
    expN = (expA.size() > MAXR) ? MAXR : expA.size();
    chk(recvIdx == expN, "R2", "record total", longint'(recvIdx), longint'(expN));
    chk(recCount == 7'(expN), "R11", "recCount", longint'(recCount), longint'(expN));
    chk(overflow == (expA.size() > MAXR), "R11", "overflow", longint'(overflow),
        longint'(expA.size() > MAXR));
    chk(doneCnt == 1, "R12", "done pulses", longint'(doneCnt), 1);
    chk(busy == 1'b0, "R12", "busy after done", longint'(busy), 0);
  endtask

  function automatic logic [63:0] mkMap(input int tr, input int tc, input int en);
    return {32'd0, 8'(tr), 8'(tc), 16'(en)};
  endfunction

  function automatic logic [63:0] mkDesc(input bit rep, input int len, input logic [23:0] a);
    return {24'd0, rep, 15'(len), a};
  endfunction

  task automatic clearCfg();
    ptrVal = 0;
    foreach (descArr[i]) descArr[i] = 0;
    foreach (mapArr[i]) mapArr[i] = 0;
  endtask

  initial begin
    void'($urandom(32'd13579));
    clearCfg();
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R13 reset state
    chk(busy == 0 && busReq == 0, "R13", "idle after reset", longint'({busy, busReq}), 0);
    chk(recValid == 0 && recCount == 0 && overflow == 0, "R13", "no record after reset",
        longint'({recValid, recCount, overflow}), 0);

    // R1 null pointer, R6/R7/R8 ring mix incl. zero traps and skipped rings
    clearCfg();
    mapArr[0] = mkMap(2, 1, 3);
    mapArr[2] = '1;
    mapArr[5] = mkMap(0, 2, 1);
    mapArr[7] = mkMap(1, 0, 9);
    runTest(0, 0);
    // R1 all-ones pointer
    ptrVal = '1;
    descArr[0] = mkDesc(1, 3, 24'h010040);
    runTest(1, 0);

    // R2..R5 descriptor modes, short byte counts and zero length
    clearCfg();
    ptrVal = {32'd0, LIST};
    descArr[0] = mkDesc(1, 3, 24'h010040);
    descArr[1] = mkDesc(0, 20, 24'h012000);
    descArr[2] = mkDesc(0, 5, 24'h013000);
    descArr[3] = mkDesc(1, 0, 24'h014000);
    descArr[4] = mkDesc(0, 24, 24'hABCDE8);
    descArr[5] = '1;
    runTest(0, 0);

    // R11 overflow with backpressure, then cleared by the next start
    clearCfg();
    mapArr[3] = mkMap(70, 0, 0);
    runTest(1, 0);
    clearCfg();
    mapArr[1] = mkMap(1, 1, 2);
    runTest(0, 0);

    // R12 start while busy is ignored
    clearCfg();
    mapArr[4] = mkMap(10, 2, 8);
    runTest(1, 1);

    // random configurations
    for (int n = 0; n < 14; n++) begin
      int nd;
      clearCfg();
      case ($urandom % 4)
        0: ptrVal = 0;
        1: ptrVal = '1;
        default: ptrVal = {32'd0, LIST};
      endcase
      nd = $urandom % 5;
      for (int k = 0; k < nd; k++) begin
        bit rep;
        rep = 1'($urandom % 2);
        descArr[k] = mkDesc(rep, rep ? int'($urandom % 5) : int'($urandom % 40),
                            24'h010000 + 24'(($urandom % 64) * 256));
      end
      descArr[nd] = ($urandom % 2) ? '1 : 64'd0;
      for (int r = 0; r < 8; r++) begin
        case ($urandom % 4)
          0: mapArr[r] = 0;
          1: mapArr[r] = '1;
          default: mapArr[r] = mkMap($urandom % 4, $urandom % 3, $urandom % 4);
        endcase
      end
      runTest(1'(n % 2), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule